// File: doc/BRIEF.md
# AES3 Preamble Synchroniser and Subframe Slicer

This block sits after a clock-recovery stage that has already sampled the line once per unit interval (UI). Each sample arrives as a level on `line_in`, and each sample is qualified by a one-clock strobe on `ui_en`. The block looks for the three preamble shapes that open every 64-UI subframe. It accepts a preamble in either absolute polarity. After a preamble it slices the next 28 bi-phase-mark slots into data bits. For each subframe it presents a 32-bit word, the kind of preamble that opened it, and two error flags: one for a coding violation and one for a sequence violation.

The preamble kind separates channel one (X), channel two (Y) and the first frame of a 192-frame block (Z). The block keeps a frame count from the last Z so that a block start arriving early or late is flagged. It also flags a break in the alternation of channel one and channel two. A lock flag shows whether preambles are arriving exactly one subframe apart. A one-clock pulse reports the moment that lock is lost.

Top module: `aes3_preamble_sync`

## Requirements
- R1: A preamble is recognised on the `ui_en` tick of its eighth UI. The eight UI levels, first UI first, are compared after normalising them so that the first UI is 1. The normalised shape must be 11100010 for X, 11100100 for Y or 11101000 for Z, and the UI before the preamble must differ from its first UI. `sf_kind` encodes 1 for X, 2 for Y and 3 for Z.
- R2: The bitwise inverse of each shape, preceded by the opposite level, is accepted as the same preamble kind.
- R3: After an accepted preamble, each of the next 28 slots spans two UIs. The slot decodes to 1 when its two UIs differ and to 0 when they are equal. The slot at subframe position s (4..31) lands in `sf_word[s]`, and `sf_word[3:0]` is 0. `sf_valid` is high for one clock, in the clock after the tick of the 56th data UI.
- R4: `sf_code_err` is reported with the word. It is 1 when the first UI of any data slot equals the UI just before it, that is, when a transition is missing at a slot boundary.
- R5: While unlocked, any recognised preamble is accepted and restarts the subframe. `locked` rises when an accepted preamble arrives exactly 64 UI ticks after the previous accepted one.
- R6: While locked, only a preamble arriving exactly 64 UI ticks after the previous one is accepted. A preamble seen at any other spacing is ignored and does not restart the data slicing.
- R7: While locked, if no preamble is recognised on the tick 64 UIs after the last one, `locked` falls and `lock_lost` pulses for one clock. The X/Y alternation history and the block-start history are then cleared.
- R8: `sf_seq_err` is reported with the word. It is 1 when a Y follows a Y, or when an X or a Z follows an X or a Z.
- R9: Once a Z has been seen, `sf_seq_err` is also 1 in two cases: when a Z arrives other than 192 frames after the previous Z, and when an X arrives where frame 192 (the next Z) is due.
- R10: Clocks with `ui_en` low leave every piece of state unchanged, so any spacing of UI ticks gives the same decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ui_en | input | 1 | Strobe marking one unit-interval sample |
| line_in | input | 1 | Line level for the current unit interval |
| sf_valid | output | 1 | One-clock pulse: subframe result ready |
| sf_word | output | 32 | Decoded subframe, slot s at bit s |
| sf_kind | output | 2 | Preamble kind: 1 = X, 2 = Y, 3 = Z |
| sf_code_err | output | 1 | A slot boundary lacked a transition |
| sf_seq_err | output | 1 | Preamble order or block spacing violated |
| locked | output | 1 | Preambles are arriving one subframe apart |
| lock_lost | output | 1 | One-clock pulse when an expected preamble is missing |

## Verification
The stimulus builds real bi-phase-mark streams. The bench draws a random parity slot for every subframe, so the preamble polarity flips throughout the run. This separates true polarity handling from a detector that only knows one shape.

A run of more than one block checks that a Z arriving exactly 192 frames after the last one passes cleanly. Deliberate sequence faults must then be flagged: a repeated X, an early Z, and an X where a Z is due. Three further streams each test one rule on its own: a subframe with a missing preamble, a subframe cut short so its preamble arrives early, and a slot with a missing boundary transition. They separate loss of lock, the ignoring of off-grid preambles, and the coding flag.

A section with irregular gaps between UI strobes checks that only qualified samples move any state.

// File: rtl/aes3_sync_pkg.sv
package aes3_sync_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_X    = 2'd1,
    PK_Y    = 2'd2,
    PK_Z    = 2'd3
  } pkind_t;

  localparam int PRE_UI = 8;

  // Normalised shapes, first UI in the MSB, first UI always 1.
  localparam logic [PRE_UI-1:0] SHAPE_X = 8'b1110_0010;
  localparam logic [PRE_UI-1:0] SHAPE_Y = 8'b1110_0100;
  localparam logic [PRE_UI-1:0] SHAPE_Z = 8'b1110_1000;

endpackage

// File: rtl/aes3_pre_match.sv
module aes3_pre_match
  import aes3_sync_pkg::*;
(
  input  logic [PRE_UI:0] win,
  output pkind_t          kind
);

  logic [PRE_UI-1:0] body;
  logic [PRE_UI-1:0] norm;
  logic              edge_ok;

  always_comb begin
    body    = win[PRE_UI-1:0];
    norm    = win[PRE_UI-1] ? body : ~body;
    edge_ok = win[PRE_UI] != win[PRE_UI-1];
    kind    = PK_NONE;
    if (edge_ok) begin
      if (norm == SHAPE_X)      kind = PK_X;
      else if (norm == SHAPE_Y) kind = PK_Y;
      else if (norm == SHAPE_Z) kind = PK_Z;
    end
  end

endmodule

// File: rtl/aes3_frame_track.sv
module aes3_frame_track
  import aes3_sync_pkg::*;
#(
  parameter int UI_PER_SF    = 64,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ui_en,
  input  pkind_t det,
  output logic   accept,
  output logic   seq_err,
  output logic   locked,
  output logic   lock_lost
);

  localparam int CNT_W  = $clog2(UI_PER_SF) + 1;
  localparam int FIDX_W = $clog2(BLOCK_FRAMES);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  GAP_DUE   = CNT_W'(UI_PER_SF - 1);
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(BLOCK_FRAMES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lock_q, lock_d;
  logic              lost_q, lost_d;
  pkind_t            prev_q, prev_d;
  logic              zseen_q, zseen_d;
  logic [FIDX_W-1:0] fidx_q, fidx_d;
  logic              gap_ok, miss, prev_ch1;

  always_comb begin
    gap_ok   = cnt_q == GAP_DUE;
    accept   = ui_en && (det != PK_NONE) && (!lock_q || gap_ok);
    miss     = ui_en && lock_q && gap_ok && !accept;
    prev_ch1 = (prev_q == PK_X) || (prev_q == PK_Z);
    case (det)
      PK_Y:    seq_err = prev_q == PK_Y;
      PK_X:    seq_err = prev_ch1 || (zseen_q && fidx_q == FIDX_LAST);
      PK_Z:    seq_err = prev_ch1 || (zseen_q && fidx_q != FIDX_LAST);
      default: seq_err = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d   = cnt_q;
    lock_d  = lock_q;
    lost_d  = 1'b0;
    prev_d  = prev_q;
    zseen_d = zseen_q;
    fidx_d  = fidx_q;
    if (ui_en) begin
      if (accept) begin
        cnt_d  = '0;
        lock_d = gap_ok;
        prev_d = det;
        if (det == PK_Z) begin
          zseen_d = 1'b1;
          fidx_d  = '0;
        end else if (det == PK_X && fidx_q != FIDX_LAST) begin
          fidx_d = fidx_q + 1'b1;
        end
      end else begin
        if (miss) begin
          lock_d  = 1'b0;
          lost_d  = 1'b1;
          prev_d  = PK_NONE;
          zseen_d = 1'b0;
        end
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      lock_q  <= 1'b0;
      lost_q  <= 1'b0;
      prev_q  <= PK_NONE;
      zseen_q <= 1'b0;
      fidx_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      lock_q  <= lock_d;
      lost_q  <= lost_d;
      prev_q  <= prev_d;
      zseen_q <= zseen_d;
      fidx_q  <= fidx_d;
    end
  end

  assign locked    = lock_q;
  assign lock_lost = lost_q;

endmodule

// File: rtl/aes3_bmc_slicer.sv
module aes3_bmc_slicer #(
  parameter int DATA_SLOTS = 28,
  parameter int TAG_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ui_en,
  input  logic                  start,
  input  logic                  line_in,
  input  logic                  prev_lvl,
  input  logic [TAG_W-1:0]      tag_in,
  output logic                  out_valid,
  output logic [DATA_SLOTS-1:0] out_bits,
  output logic                  out_err,
  output logic [TAG_W-1:0]      out_tag
);

  localparam int DATA_UI = 2 * DATA_SLOTS;
  localparam int POS_W   = $clog2(DATA_UI);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(DATA_UI - 1);

  logic                  act_q, act_d;
  logic [POS_W-1:0]      pos_q, pos_d;
  logic                  first_q, first_d;
  logic [DATA_SLOTS-1:0] acc_q, acc_d;
  logic                  err_q, err_d;
  logic [TAG_W-1:0]      tag_q, tag_d;
  logic                  ov_q, ov_d;
  logic [DATA_SLOTS-1:0] ob_q, ob_d;
  logic                  oe_q, oe_d;
  logic [TAG_W-1:0]      ot_q, ot_d;

  always_comb begin
    act_d   = act_q;
    pos_d   = pos_q;
    first_d = first_q;
    acc_d   = acc_q;
    err_d   = err_q;
    tag_d   = tag_q;
    ov_d    = 1'b0;
    ob_d    = ob_q;
    oe_d    = oe_q;
    ot_d    = ot_q;
    if (ui_en) begin
      if (start) begin
        act_d = 1'b1;
        pos_d = '0;
        acc_d = '0;
        err_d = 1'b0;
        tag_d = tag_in;
      end else if (act_q) begin
        if (!pos_q[0]) begin
          if (line_in == prev_lvl) err_d = 1'b1;
          first_d = line_in;
        end else begin
          acc_d = {line_in ^ first_q, acc_q[DATA_SLOTS-1:1]};
        end
        if (pos_q == POS_LAST) begin
          act_d = 1'b0;
          ov_d  = 1'b1;
          ob_d  = acc_d;
          oe_d  = err_d;
          ot_d  = tag_q;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      pos_q   <= '0;
      first_q <= 1'b0;
      acc_q   <= '0;
      err_q   <= 1'b0;
      tag_q   <= '0;
      ov_q    <= 1'b0;
      ob_q    <= '0;
      oe_q    <= 1'b0;
      ot_q    <= '0;
    end else begin
      act_q   <= act_d;
      pos_q   <= pos_d;
      first_q <= first_d;
      acc_q   <= acc_d;
      err_q   <= err_d;
      tag_q   <= tag_d;
      ov_q    <= ov_d;
      ob_q    <= ob_d;
      oe_q    <= oe_d;
      ot_q    <= ot_d;
    end
  end

  assign out_valid = ov_q;
  assign out_bits  = ob_q;
  assign out_err   = oe_q;
  assign out_tag   = ot_q;

endmodule

// File: rtl/aes3_preamble_sync.sv
module aes3_preamble_sync
  import aes3_sync_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ui_en,
  input  logic              line_in,
  output logic              sf_valid,
  output logic [WORD_W-1:0] sf_word,
  output logic [1:0]        sf_kind,
  output logic              sf_code_err,
  output logic              sf_seq_err,
  output logic              locked,
  output logic              lock_lost
);

  localparam int UI_PER_SF  = 2 * WORD_W;
  localparam int PRE_SLOTS  = PRE_UI / 2;
  localparam int DATA_SLOTS = WORD_W - PRE_SLOTS;
  localparam int TAG_W      = 3;

  logic [PRE_UI-1:0]     hist_q, hist_d;
  logic [PRE_UI:0]       win;
  pkind_t                det;
  logic                  accept, seq_err;
  logic [DATA_SLOTS-1:0] bits;
  logic [TAG_W-1:0]      tag;

  always_comb begin
    win    = {hist_q, line_in};
    hist_d = ui_en ? {hist_q[PRE_UI-2:0], line_in} : hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  aes3_pre_match u_match (
    .win  (win),
    .kind (det)
  );

  aes3_frame_track #(
    .UI_PER_SF    (UI_PER_SF),
    .BLOCK_FRAMES (BLOCK_FRAMES)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ui_en     (ui_en),
    .det       (det),
    .accept    (accept),
    .seq_err   (seq_err),
    .locked    (locked),
    .lock_lost (lock_lost)
  );

  aes3_bmc_slicer #(
    .DATA_SLOTS (DATA_SLOTS),
    .TAG_W      (TAG_W)
  ) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .ui_en     (ui_en),
    .start     (accept),
    .line_in   (line_in),
    .prev_lvl  (hist_q[0]),
    .tag_in    ({seq_err, det}),
    .out_valid (sf_valid),
    .out_bits  (bits),
    .out_err   (sf_code_err),
    .out_tag   (tag)
  );

  assign sf_word    = {bits, {PRE_SLOTS{1'b0}}};
  assign sf_kind    = tag[1:0];
  assign sf_seq_err = tag[2];

endmodule

// File: rtl/aes3_sync_chk.sv
module aes3_sync_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ui_en,
  input logic              line_in,
  input logic              sf_valid,
  input logic [WORD_W-1:0] sf_word,
  input logic [1:0]        sf_kind,
  input logic              sf_code_err,
  input logic              sf_seq_err,
  input logic              locked,
  input logic              lock_lost
);

  p_kind_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> sf_kind != 2'd0);

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |=> !sf_valid);

  p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ui_en));

  p_lost_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> !locked);

  p_lost_from_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> $past(locked));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ui_en |=> $stable(locked));

endmodule

bind aes3_preamble_sync aes3_sync_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_aes3_preamble_sync.sv
`timescale 1ns/1ps
module sim_aes3_preamble_sync;

  logic        clk;
  logic        rst_n;
  logic        ui_en;
  logic        line_in;
  logic        sf_valid;
  logic [31:0] sf_word;
  logic [1:0]  sf_kind;
  logic        sf_code_err;
  logic        sf_seq_err;
  logic        locked;
  logic        lock_lost;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  aes3_preamble_sync u0 (
    .clk(clk), .rst_n(rst_n), .ui_en(ui_en), .line_in(line_in),
    .sf_valid(sf_valid), .sf_word(sf_word), .sf_kind(sf_kind),
    .sf_code_err(sf_code_err), .sf_seq_err(sf_seq_err),
    .locked(locked), .lock_lost(lock_lost)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [8:0]  m_win;
  bit          m_line_hist[$];
  int          m_since, m_prev, m_fidx;
  bit          m_lock, m_zseen, m_act, m_first, m_err, m_tserr;
  int          m_pos, m_tkind, m_kind;
  bit [27:0]   m_acc;
  bit          e_valid, e_cerr, e_serr, e_lost;
  bit [31:0]   e_word;
  int          e_kind;
  int          n_words = 0;

  function automatic int classify(input logic [8:0] w);
    logic [7:0] b;
    if (w[8] == w[7]) return 0;
    b = w[7] ? w[7:0] : ~w[7:0];
    if (b == 8'hE2) return 1;
    if (b == 8'hE4) return 2;
    if (b == 8'hE8) return 3;
    return 0;
  endfunction

  task automatic model_reset();
    m_line_hist = {};
    repeat (8) m_line_hist.push_back(1'b0);
    m_since = 1000; m_prev = 0; m_fidx = 0; m_lock = 0; m_zseen = 0;
    m_act = 0; m_pos = 0; m_first = 0; m_err = 0; m_acc = '0;
    m_tkind = 0; m_tserr = 0;
    e_valid = 0; e_cerr = 0; e_serr = 0; e_lost = 0; e_word = '0; e_kind = 0;
  endtask

  task automatic model_step(input bit v);
    int  k;
    bit  take, serr, prevlvl;
    e_valid = 0;
    e_lost  = 0;
    for (int i = 0; i < 8; i++) m_win[8-i] = m_line_hist[i];
    m_win[0] = v;
    k = classify(m_win);
    prevlvl = m_line_hist[7];
    take = (k != 0) && (!m_lock || m_since == 63);
    serr = 0;
    if (k == 2) serr = (m_prev == 2);
    if (k == 1) serr = (m_prev == 1 || m_prev == 3) || (m_zseen && m_fidx == 191);
    if (k == 3) serr = (m_prev == 1 || m_prev == 3) || (m_zseen && m_fidx != 191);
    // data slicing
    if (take) begin
      m_act = 1; m_pos = 0; m_acc = '0; m_err = 0; m_tkind = k; m_tserr = serr;
    end else if (m_act) begin
      if (m_pos % 2 == 0) begin
        if (v == prevlvl) m_err = 1;
        m_first = v;
      end else begin
        m_acc[m_pos/2] = v ^ m_first;
      end
      if (m_pos == 55) begin
        m_act = 0; e_valid = 1; e_word = {m_acc, 4'b0000};
        e_cerr = m_err; e_kind = m_tkind; e_serr = m_tserr;
        n_words++;
      end else m_pos++;
    end
    // framing
    if (take) begin
      m_lock = (m_since == 63);
      m_since = 0;
      m_prev = k;
      if (k == 3) begin m_zseen = 1; m_fidx = 0; end
      else if (k == 1 && m_fidx != 191) m_fidx++;
    end else begin
      if (m_lock && m_since == 63) begin
        m_lock = 0; e_lost = 1; m_prev = 0; m_zseen = 0;
      end
      if (m_since < 127) m_since++;
    end
    void'(m_line_hist.pop_front());
    m_line_hist.push_back(v);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      if (ui_en) model_step(line_in);
      else begin e_valid = 0; e_lost = 0; end
      #2;
      check(locked == m_lock, "R5 R6 locked", locked, m_lock);
      check(lock_lost == e_lost, "R7 lock_lost", lock_lost, e_lost);
      check(sf_valid == e_valid, "R3 R10 sf_valid", sf_valid, e_valid);
      if (e_valid) begin
        check(sf_word == e_word, "R3 sf_word", sf_word, e_word);
        check(sf_kind == 2'(e_kind), "R1 R2 sf_kind", sf_kind, e_kind);
        check(sf_code_err == e_cerr, "R4 sf_code_err", sf_code_err, e_cerr);
        check(sf_seq_err == e_serr, "R8 R9 sf_seq_err", sf_seq_err, e_serr);
      end
    end
  end

  // ---------------- stimulus ----------------
  bit lvl = 0;
  int gap_max = 0;
  bit saw_inv = 0;

  task automatic send_ui(input bit v);
    @(negedge clk);
    line_in = v;
    ui_en = 1'b1;
    @(negedge clk);
    ui_en = 1'b0;
    if (gap_max > 0) repeat ($urandom_range(gap_max)) @(negedge clk);
  endtask

  // kind: 1 X, 2 Y, 3 Z; nslots data slots; skip_pre replaces preamble with data; bad_slot hides a boundary edge
  task automatic send_sf(input int kind, input int nslots, input bit skip_pre, input int bad_slot);
    logic [7:0] shp;
    bit f, s;
    bit [27:0] d;
    d = 28'($urandom);
    if (skip_pre) begin
      for (int i = 0; i < 4; i++) begin
        f = ~lvl; send_ui(f); s = d[i] ? ~f : f; send_ui(s); lvl = s;
      end
    end else begin
      shp = (kind == 1) ? 8'hE2 : (kind == 2) ? 8'hE4 : 8'hE8;
      if (lvl) saw_inv = 1;
      s = lvl;
      for (int i = 7; i >= 0; i--) send_ui(shp[i] ^ s);
      lvl = shp[0] ^ s;
    end
    for (int i = 0; i < nslots; i++) begin
      f = (i == bad_slot) ? lvl : ~lvl;
      send_ui(f);
      s = d[i] ? ~f : f;
      send_ui(s);
      lvl = s;
    end
  endtask

  task automatic send_frame(input int f);
    send_sf((f % 192 == 0) ? 3 : 1, 28, 0, -1);
    send_sf(2, 28, 0, -1);
  endtask

  initial begin
    int w0;
    rst_n = 1'b0; ui_en = 1'b0; line_in = 1'b0;
    repeat (3) @(negedge clk);
    check(locked == 0 && sf_valid == 0 && lock_lost == 0, "R5 reset state", locked, 0);
    rst_n = 1'b1;

    // full block plus a few frames, random parity mixes polarities
    for (int f = 0; f < 200; f++) send_frame(f);
    #3;
    check(locked == 1, "R5 locked after stream", locked, 1);
    check(saw_inv == 1, "R2 inverse preambles sent", saw_inv, 1);

    // sequence faults: repeated X, early Z, then X where Z is due
    send_sf(1, 28, 0, -1);
    send_sf(1, 28, 0, -1);
    send_sf(2, 28, 0, -1);
    send_frame(0);
    for (int f = 1; f < 5; f++) send_frame(f);
    send_frame(0);
    for (int f = 1; f < 192; f++) send_frame(f);
    send_sf(1, 28, 0, -1);
    send_sf(2, 28, 0, -1);

    // coding error in one slot
    send_sf(1, 28, 0, 9);
    send_sf(2, 28, 0, -1);
    #3;
    check(locked == 1, "R4 lock kept through coding error", locked, 1);

    // missing preamble
    send_sf(1, 28, 1, -1);
    #3;
    check(locked == 0, "R7 lock dropped on missing preamble", locked, 0);
    for (int f = 0; f < 3; f++) send_frame(f);
    #3;
    check(locked == 1, "R5 relock", locked, 1);

    // short subframe: early preamble ignored while locked, then lock lost
    w0 = n_words;
    send_sf(1, 12, 0, -1);
    send_sf(2, 28, 0, -1);
    send_sf(1, 28, 0, -1);
    #3;
    check(n_words > w0, "R6 words after early preamble", n_words, w0 + 1);
    for (int f = 0; f < 3; f++) send_frame(f);

    // irregular UI spacing
    gap_max = 2;
    for (int f = 0; f < 10; f++) send_frame(f);
    gap_max = 0;
    #3;
    check(locked == 1, "R10 locked with gapped strobes", locked, 1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule